// File: doc/BRIEF.md
# Low-speed clock switchover sequencer

This block decides where the low-speed system clock comes from after the chip leaves stop mode. A wake trigger starts the internal RC oscillator in every clock mode. Once a set number of RC cycles has been counted, the block declares the clock valid with the RC oscillator as its source. If the system clock is the low-speed clock, the block also issues a one-cycle strobe that lets program execution resume.

The clock mode is captured when the wake trigger arrives. In crystal mode, the block counts crystal cycles from the wake onward, and the crystal cycles begin only after the crystal's own start-up time. In external-clock mode, it counts external clock cycles instead. Once the target count has been reached, the block moves the source from RC to the final source on the next RC cycle boundary and marks the change with a one-cycle strobe. In RC-only mode, the RC oscillator stays the source. A stop request clears everything and parks the block until the next wake.

Oscillator edges arrive as single-cycle enable pulses in the block's own clock domain. Analog clock muxing and oscillator start-up physics are modelled only through these pulses.

Top module: `lsw_switchover`

## Requirements
- R1: While reset is held and after reset is released, `src_sel` is 2'b00 (no source), `clk_valid` is 0, and both strobes are 0, until a wake is accepted.
- R2: A stop request forces the block to the stopped state (source 2'b00, `clk_valid` 0) on the next cycle and clears all edge counts. A stop request takes priority over a wake request in the same cycle.
- R3: A wake request seen in the stopped state starts the RC warm-up whatever the mode. The mode on `clk_mode` is captured in that cycle, and later changes to `clk_mode` are ignored until the next wake.
- R4: RC ticks are counted from the cycle after the wake cycle. One cycle after the clock edge that captures the RC_COUNT-th tick (default 512), `clk_valid` rises and `src_sel` becomes 2'b01 (RC).
- R5: `resume_strobe` is a single-cycle pulse in the cycle in which `clk_valid` rises. It is issued only if `lsclk_is_sys` was 1 on the edge at which `clk_valid` rose.
- R6: With `clk_mode` 2'b01 (crystal), crystal ticks are counted from the cycle after the wake, up to XT_COUNT (default 8192). After the count is complete and the source is RC, the first RC tick moves `src_sel` to 2'b10 (crystal) on the next cycle.
- R7: With `clk_mode` 2'b10 (external), the same rule applies with external ticks and EXT_COUNT (default 16). The final source is 2'b11 (external).
- R8: With `clk_mode` 2'b00 or 2'b11 (RC only), the source stays at 2'b01 and no switch strobe is ever issued.
- R9: `switch_strobe` is high for exactly the one cycle in which `src_sel` first shows the final source after 2'b01. It occurs exactly once per wake in crystal and external modes.
- R10: A wake request while the block is not stopped has no effect on the source, validity or counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Enter stop mode; clears the counts |
| wake_req | input | 1 | Wake trigger from an enabled external interrupt |
| clk_mode | input | 2 | 00/11 RC only, 01 crystal, 10 external clock |
| lsclk_is_sys | input | 1 | System clock is the low-speed clock |
| rc_tick | input | 1 | One pulse per RC oscillator cycle |
| xt_tick | input | 1 | One pulse per crystal cycle |
| ext_tick | input | 1 | One pulse per external clock cycle |
| src_sel | output | 2 | 00 none, 01 RC, 10 crystal, 11 external |
| clk_valid | output | 1 | Low-speed clock is being delivered |
| resume_strobe | output | 1 | One-cycle program-resume pulse |
| switch_strobe | output | 1 | One-cycle pulse marking the RC-to-final source change |

## Verification
The bound checker watches several behaviours on every cycle:
- a stop request always empties the source on the next cycle;
- validity never rises before exactly RC_COUNT RC ticks have been seen during warm-up, and the source is then RC;
- the resume strobe is single and coincides with the rise of `clk_valid`;
- the switch strobe appears exactly when the source leaves RC for a final source, and never in RC-only mode.

Some behaviours only the bench scenarios can show, through a cycle-level reference model and directed end-of-scenario checks:
- the target counts themselves: 8192 crystal and 16 external ticks, including a crystal start-up delay;
- the wait for the RC boundary;
- mode changes after the wake being ignored;
- counts being cleared when stop interrupts a warm-up.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

   typedef enum logic [1:0] {
      ST_STOP  = 2'd0,
      ST_WARM  = 2'd1,
      ST_RCRUN = 2'd2,
      ST_FINAL = 2'd3
   } lsw_state_e;

   localparam logic [1:0] MODE_RC     = 2'b00;
   localparam logic [1:0] MODE_XT     = 2'b01;
   localparam logic [1:0] MODE_EXT    = 2'b10;
   localparam logic [1:0] MODE_RC_ALT = 2'b11;

   localparam logic [1:0] SRC_NONE = 2'b00;
   localparam logic [1:0] SRC_RC   = 2'b01;
   localparam logic [1:0] SRC_XT   = 2'b10;
   localparam logic [1:0] SRC_EXT  = 2'b11;

   function automatic logic mode_has_target(input logic [1:0] m);
      return (m == MODE_XT) || (m == MODE_EXT);
   endfunction

endpackage

// File: rtl/lsw_edge_counter.sv
module lsw_edge_counter #(
   parameter int unsigned WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tick,
   input  logic [WIDTH-1:0] limit,
   output logic             done
);

   logic [WIDTH-1:0] cnt_q;

   // Saturates at the limit; done stays high until cleared.
   assign done = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (en && tick && !done) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lsw_fsm.sv
module lsw_fsm
   import lsw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       wake_req,
   input  logic [1:0] mode_in,
   input  logic       lsclk_is_sys,
   input  logic       rc_tick,
   input  logic       rc_done,
   input  logic       tgt_done,
   output lsw_state_e state_q,
   output logic [1:0] mode_q,
   output logic       resume_q,
   output logic       switch_q
);

   lsw_state_e state_d;
   logic [1:0] mode_d;
   logic       resume_d;
   logic       switch_d;

   always_comb begin
      state_d  = state_q;
      mode_d   = mode_q;
      resume_d = 1'b0;
      switch_d = 1'b0;
      if (stop_req) begin
         state_d = ST_STOP;
      end else begin
         unique case (state_q)
            ST_STOP: begin
               if (wake_req) begin
                  state_d = ST_WARM;
                  mode_d  = mode_in;
               end
            end
            ST_WARM: begin
               if (rc_done) begin
                  state_d  = ST_RCRUN;
                  resume_d = lsclk_is_sys;
               end
            end
            ST_RCRUN: begin
               // Switch only on an RC cycle boundary once the target count is met.
               if (mode_has_target(mode_q) && tgt_done && rc_tick) begin
                  state_d  = ST_FINAL;
                  switch_d = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_STOP;
         mode_q   <= MODE_RC;
         resume_q <= 1'b0;
         switch_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         mode_q   <= mode_d;
         resume_q <= resume_d;
         switch_q <= switch_d;
      end
   end

endmodule

// File: rtl/lsw_switchover.sv
module lsw_switchover
   import lsw_pkg::*;
#(
   parameter int unsigned RC_COUNT       = 512,
   parameter int unsigned XT_COUNT       = 8192,
   parameter int unsigned EXT_COUNT      = 16,
   parameter bit          SHARED_TGT_CNT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       wake_req,
   input  logic [1:0] clk_mode,
   input  logic       lsclk_is_sys,
   input  logic       rc_tick,
   input  logic       xt_tick,
   input  logic       ext_tick,
   output logic [1:0] src_sel,
   output logic       clk_valid,
   output logic       resume_strobe,
   output logic       switch_strobe
);

   localparam int unsigned RC_W    = $clog2(RC_COUNT + 1);
   localparam int unsigned TGT_MAX = (XT_COUNT > EXT_COUNT) ? XT_COUNT : EXT_COUNT;
   localparam int unsigned TGT_W   = $clog2(TGT_MAX + 1);

   generate
      if (RC_COUNT < 1 || XT_COUNT < 1 || EXT_COUNT < 1) begin : g_bad_count
         $error("lsw_switchover: every edge count must be at least 1");
      end
   endgenerate

   lsw_state_e st;
   logic [1:0] mode_q;
   logic       cnt_clr;
   logic       rc_done;
   logic       tgt_done;
   logic       tgt_en;

   assign cnt_clr = stop_req || (st == ST_STOP);
   assign tgt_en  = (st != ST_STOP) && mode_has_target(mode_q);

   lsw_edge_counter #(.WIDTH(RC_W)) u_rc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (st == ST_WARM),
      .tick  (rc_tick),
      .limit (RC_W'(RC_COUNT)),
      .done  (rc_done)
   );

   generate
      if (SHARED_TGT_CNT) begin : g_shared
         logic             sel_tick;
         logic [TGT_W-1:0] sel_limit;
         assign sel_tick  = (mode_q == MODE_XT) ? xt_tick : ext_tick;
         assign sel_limit = (mode_q == MODE_XT) ? TGT_W'(XT_COUNT) : TGT_W'(EXT_COUNT);
         lsw_edge_counter #(.WIDTH(TGT_W)) u_tgt_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .en    (tgt_en),
            .tick  (sel_tick),
            .limit (sel_limit),
            .done  (tgt_done)
         );
      end else begin : g_split
         localparam int unsigned XT_W  = $clog2(XT_COUNT + 1);
         localparam int unsigned EXT_W = $clog2(EXT_COUNT + 1);
         logic xt_done;
         logic ext_done;
         lsw_edge_counter #(.WIDTH(XT_W)) u_xt_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .en    (tgt_en && (mode_q == MODE_XT)),
            .tick  (xt_tick),
            .limit (XT_W'(XT_COUNT)),
            .done  (xt_done)
         );
         lsw_edge_counter #(.WIDTH(EXT_W)) u_ext_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .en    (tgt_en && (mode_q == MODE_EXT)),
            .tick  (ext_tick),
            .limit (EXT_W'(EXT_COUNT)),
            .done  (ext_done)
         );
         assign tgt_done = (mode_q == MODE_XT) ? xt_done : ext_done;
      end
   endgenerate

   lsw_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_req     (stop_req),
      .wake_req     (wake_req),
      .mode_in      (clk_mode),
      .lsclk_is_sys (lsclk_is_sys),
      .rc_tick      (rc_tick),
      .rc_done      (rc_done),
      .tgt_done     (tgt_done),
      .state_q      (st),
      .mode_q       (mode_q),
      .resume_q     (resume_strobe),
      .switch_q     (switch_strobe)
   );

   always_comb begin
      unique case (st)
         ST_RCRUN: src_sel = SRC_RC;
         ST_FINAL: src_sel = (mode_q == MODE_XT) ? SRC_XT : SRC_EXT;
         default:  src_sel = SRC_NONE;
      endcase
   end

   assign clk_valid = (st == ST_RCRUN) || (st == ST_FINAL);

endmodule

// File: rtl/lsw_switchover_chk.sv
module lsw_switchover_chk
   import lsw_pkg::*;
#(
   parameter int unsigned RC_COUNT = 512
) (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_req,
   input logic       rc_tick,
   input logic [1:0] src_sel,
   input logic       clk_valid,
   input logic       resume_strobe,
   input logic       switch_strobe,
   input lsw_state_e state,
   input logic [1:0] mode_q
);

   localparam int unsigned SEEN_W = $clog2(RC_COUNT + 1);

   logic [SEEN_W-1:0] rc_seen;

   // Independent tally of RC ticks during warm-up, saturating at the count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc_seen <= '0;
      end else if (stop_req || state == ST_STOP) begin
         rc_seen <= '0;
      end else if (state == ST_WARM && rc_tick && rc_seen != SEEN_W'(RC_COUNT)) begin
         rc_seen <= rc_seen + 1'b1;
      end
   end

   a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (src_sel == SRC_NONE && !clk_valid));

   a_r4_valid_after_rc_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_valid) |-> (rc_seen == SEEN_W'(RC_COUNT) && src_sel == SRC_RC));

   a_r5_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
      resume_strobe |=> !resume_strobe);

   a_r5_resume_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      resume_strobe |-> $rose(clk_valid));

   a_r8_rc_only_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RC || mode_q == MODE_RC_ALT) |-> !switch_strobe);

   a_r9_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      switch_strobe |-> ($past(src_sel) == SRC_RC && (src_sel == SRC_XT || src_sel == SRC_EXT)));

   a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_sel) == SRC_RC && (src_sel == SRC_XT || src_sel == SRC_EXT)) |-> switch_strobe);

endmodule

bind lsw_switchover lsw_switchover_chk #(.RC_COUNT(RC_COUNT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stop_req      (stop_req),
   .rc_tick       (rc_tick),
   .src_sel       (src_sel),
   .clk_valid     (clk_valid),
   .resume_strobe (resume_strobe),
   .switch_strobe (switch_strobe),
   .state         (st),
   .mode_q        (mode_q)
);

// File: tb/lsw_switchover_tb.sv
module lsw_switchover_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RC_N  = 512;
   localparam int XT_N  = 8192;
   localparam int EXT_N = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 1'b0;
   logic       wake_req = 1'b0;
   logic [1:0] clk_mode = 2'b00;
   logic       lsclk_is_sys = 1'b0;
   logic       rc_tick = 1'b0;
   logic       xt_tick = 1'b0;
   logic       ext_tick = 1'b0;
   logic [1:0] src_sel;
   logic       clk_valid;
   logic       resume_strobe;
   logic       switch_strobe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lsw_switchover u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .stop_req      (stop_req),
      .wake_req      (wake_req),
      .clk_mode      (clk_mode),
      .lsclk_is_sys  (lsclk_is_sys),
      .rc_tick       (rc_tick),
      .xt_tick       (xt_tick),
      .ext_tick      (ext_tick),
      .src_sel       (src_sel),
      .clk_valid     (clk_valid),
      .resume_strobe (resume_strobe),
      .switch_strobe (switch_strobe)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic bit has_target(input logic [1:0] m);
      return (m == 2'b01) || (m == 2'b10);
   endfunction

   function automatic logic [1:0] final_src(input logic [1:0] m);
      if (m == 2'b01) return 2'b10;
      if (m == 2'b10) return 2'b11;
      return 2'b01;
   endfunction

   // Reference model built from the requirements: 0 stop, 1 warm, 2 RC run, 3 final
   int         m_st, m_rc, m_tg;
   logic [1:0] m_mode;
   bit         m_res, m_sw;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_rc = 0; m_tg = 0; m_mode = 2'b00; m_res = 0; m_sw = 0;
      end else begin
         int         n_st;
         logic [1:0] n_mode;
         bit         res, sw;
         int         lim;
         bit         tk;
         n_st = m_st; n_mode = m_mode; res = 0; sw = 0;
         lim = (m_mode == 2'b01) ? XT_N : EXT_N;
         tk  = (m_mode == 2'b01) ? xt_tick : ext_tick;
         if (stop_req) n_st = 0;
         else if (m_st == 0 && wake_req) begin n_st = 1; n_mode = clk_mode; end
         else if (m_st == 1 && m_rc == RC_N) begin n_st = 2; res = lsclk_is_sys; end
         else if (m_st == 2 && has_target(m_mode) && m_tg == lim && rc_tick) begin
            n_st = 3; sw = 1;
         end
         if (stop_req || m_st == 0) begin
            m_rc = 0; m_tg = 0;
         end else begin
            if (m_st == 1 && rc_tick && m_rc < RC_N) m_rc++;
            if (has_target(m_mode) && tk && m_tg < lim) m_tg++;
         end
         m_st = n_st; m_mode = n_mode; m_res = res; m_sw = sw;
      end
   end

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [1:0] e_src;
         string      tg;
         e_src = (m_st == 0 || m_st == 1) ? 2'b00 : (m_st == 2) ? 2'b01 : final_src(m_mode);
         if (m_st == 3) tg = (m_mode == 2'b01) ? "R6" : "R7";
         else if (m_st == 2 && !has_target(m_mode)) tg = "R8";
         else tg = "R4";
         chk(src_sel == e_src, tg, "src_sel", src_sel, e_src);
         chk(clk_valid == (m_st >= 2), "R4", "clk_valid", clk_valid, m_st >= 2);
         chk(resume_strobe == m_res, "R5", "resume_strobe", resume_strobe, m_res);
         chk(switch_strobe == m_sw, "R9", "switch_strobe", switch_strobe, m_sw);
      end
   end

   task automatic scenario(input logic [1:0] mode, input bit lsys, input int cycles, input int stop_at);
      int sw_seen = 0;
      int res_seen = 0;
      int xt_start = $urandom % 200;
      @(negedge clk);
      wake_req = 1; clk_mode = mode; lsclk_is_sys = lsys;
      rc_tick = $urandom % 2; xt_tick = 0; ext_tick = $urandom % 2;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         sw_seen  += switch_strobe;
         res_seen += resume_strobe;
         // Late wake pulses only when no stop is planned (R10); mode scrambled (R3)
         wake_req = (stop_at < 0) && (c % 97 == 50);
         clk_mode = 2'($urandom);
         rc_tick  = ($urandom % 2) == 0;
         xt_tick  = (c >= xt_start) && (($urandom % 4) != 0);
         ext_tick = ($urandom % 3) == 0;
         stop_req = (c == stop_at);
      end
      @(negedge clk);
      sw_seen  += switch_strobe;
      res_seen += resume_strobe;
      wake_req = 0; stop_req = 0; rc_tick = 0; xt_tick = 0; ext_tick = 0;
      if (stop_at < 0) begin
         chk(src_sel == final_src(mode), "R3/R10 final source", "src_sel", src_sel, final_src(mode));
         chk(sw_seen == (has_target(mode) ? 1 : 0), "R9 strobe count", "switch count",
             sw_seen, has_target(mode) ? 1 : 0);
         chk(res_seen == (lsys ? 1 : 0), "R5 resume count", "resume count", res_seen, lsys ? 1 : 0);
      end
      stop_req = 1;
      @(negedge clk);
      stop_req = 0;
      chk(src_sel == 2'b00 && !clk_valid, "R2 after stop", "src/valid",
          {src_sel, clk_valid}, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C1C));
      repeat (3) @(negedge clk);
      chk(src_sel == 2'b00, "R1 in reset", "src_sel", src_sel, 0);
      chk(!clk_valid && !resume_strobe && !switch_strobe, "R1 in reset", "valid/strobes",
          {clk_valid, resume_strobe, switch_strobe}, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk(src_sel == 2'b00 && !clk_valid, "R1 after reset", "src/valid", {src_sel, clk_valid}, 0);

      // R2: stop and wake together; stop wins and the block stays empty
      stop_req = 1; wake_req = 1; clk_mode = 2'b10;
      @(negedge clk);
      stop_req = 0; wake_req = 0;
      repeat (3) @(negedge clk);
      chk(src_sel == 2'b00 && !clk_valid, "R2 stop beats wake", "src/valid", {src_sel, clk_valid}, 0);

      scenario(2'b00, 1'b1, 1500, -1);   // R8 RC only
      scenario(2'b11, 1'b0, 1500, -1);   // R8 alternate RC-only code, no resume
      scenario(2'b10, 1'b1, 2000, -1);   // R7 external
      scenario(2'b10, 1'b1, 600, 300);   // R2 stop inside warm-up
      scenario(2'b10, 1'b0, 2000, -1);   // R7 again after a cleared count
      scenario(2'b01, 1'b1, 13000, -1);  // R6 crystal
      scenario(2'b01, 1'b1, 6000, 5000); // R2 stop before the crystal count completes
      scenario(2'b01, 1'b0, 13000, -1);  // R6 recount from zero

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule